// File: doc/BRIEF.md
# Bit-Oriented Transmit Abort and Interrupt-Pending Controller

This block controls the transmit side of a synchronous serial channel that runs a bit-oriented framing mode. Software writes 3-bit command codes through a strobe port and loads characters through a data-load strobe. The block keeps a one-character holding buffer and a shifter. On each bit-clock enable the shifter sends one bit of the character onto the serial line, least significant bit first. When nothing is being sent, the line idles at mark (1).

An abort command empties the holding buffer and drops any character in the shifter. It sets an underrun/end-of-message status bit and drives a fixed run of 1 bits onto the line. The block also keeps a transmit interrupt-pending flag. The flag sets when the holding buffer goes from full to empty. A reset-pending command clears the flag and sets a suppression latch. While that latch is set, further buffer-empty events raise no interrupt. The latch clears on the next accepted load or when the CRC engine reports that CRC transmission is complete.

Top module: `tx_abort_ctl`

## Requirements
- R1: After reset, bufFull, intPending, txIrq, eomFlag and abortBusy are 0, and txBit is 1.
- R2: A loadValid that is accepted sets bufFull in the next cycle and clears intPending and eomFlag. A load is accepted only when no abort run is active and no abort command arrives in the same cycle.
- R3: If bitEn is high while the shifter is idle, the buffer is full and no abort is active, the character moves into the shifter and the buffer empties. In that cycle txBit stays 1. On each of the next DATA_W bitEn cycles, txBit presents one data bit, least significant bit first. When the shifter is idle, txBit is 1.
- R4: intPending sets when the buffer goes from full to empty while the suppression latch is clear. txIrq is high exactly when intPending and txIntEn are both 1.
- R5: Command code 3'b101 clears intPending and sets the suppression latch. A later full-to-empty event then leaves intPending at 0.
- R6: The suppression latch clears on an accepted load or on a crcDone pulse. After that, a full-to-empty event sets intPending again.
- R7: Command code 3'b011 with frameMode=1 has these effects in the next cycle: bufFull is 0, the shifter is cleared, eomFlag is 1 and abortBusy is 1. txBit then stays 1 for exactly ABORT_LEN bitEn cycles. After the last of them, abortBusy returns to 0.
- R8: Command code 3'b011 with frameMode=0 is ignored. Command codes other than 3'b011 and 3'b101 are ignored.
- R9: A load that arrives during an abort run, or in the same cycle as the abort command, is dropped. The buffer stays empty.
- R10: If a 3'b101 command and a full-to-empty event fall in the same cycle, intPending is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameMode | input | 1 | 1 selects the bit-oriented framing mode |
| cmdValid | input | 1 | Command write strobe |
| cmdCode | input | 3 | Command code |
| loadValid | input | 1 | Character load strobe |
| loadData | input | DATA_W | Character to load |
| crcDone | input | 1 | Pulse when CRC transmission is complete |
| txIntEn | input | 1 | Transmit interrupt enable |
| bitEn | input | 1 | Bit-clock enable |
| txBit | output | 1 | Serial data output |
| abortBusy | output | 1 | An abort run of 1s is in progress |
| bufFull | output | 1 | Holding buffer is full |
| intPending | output | 1 | Transmit interrupt pending |
| txIrq | output | 1 | Transmit interrupt request |
| eomFlag | output | 1 | Underrun/end-of-message status |

## Verification
Directed sequences cover several cases:
- Draining a character with suppression clear, with suppression set, and after suppression is lifted by crcDone. This separates the set, block and lift paths of the pending flag.
- An all-zero character in flight when an abort arrives. This makes the forced 1s distinguishable from data and shows that the shifter is flushed.
- Abort in the other framing mode, and a load during the run. These show that both stimuli are dropped.
- A reset-pending command that coincides with a drain, which checks the command's priority over the set path.

A seeded random phase mixes loads, bit enables, commands of every code, CRC pulses and mode changes. It compares every output on every cycle against a bench reference model. This exposes ordering interactions that the directed cases miss.

// File: rtl/tx_abort_pkg.sv
package tx_abort_pkg;

  typedef enum logic [2:0] {
    CMD_ABORT    = 3'b011,
    CMD_PEND_CLR = 3'b101
  } txCmd_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic takeLoad;
    logic startAbort;
  } txStrobes_t;

endpackage

// File: rtl/tx_abort_ctrl.sv
module tx_abort_ctrl
  import tx_abort_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameMode,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       loadValid,
  input  logic       crcDone,
  input  logic       txIntEn,
  input  logic       abortBusy,
  input  logic       drainPulse,
  output txStrobes_t strobes,
  output logic       intPending,
  output logic       txIrq,
  output logic       eomFlag
);

  logic abortCmd;
  logic pendClrCmd;
  logic suppress;

  always_comb begin
    abortCmd           = cmdValid && (cmdCode == CMD_ABORT) && frameMode;
    pendClrCmd         = cmdValid && (cmdCode == CMD_PEND_CLR);
    strobes.startAbort = abortCmd;
    strobes.takeLoad   = loadValid && !abortBusy && !abortCmd;
  end

  // Pending flag: the clear command has priority over a load, and a load over a set.
  always_ff @(posedge clk) begin
    if (!rstN)                          intPending <= 1'b0;
    else if (pendClrCmd)                intPending <= 1'b0;
    else if (strobes.takeLoad)          intPending <= 1'b0;
    else if (drainPulse && !suppress)   intPending <= 1'b1;
  end

  // Suppression latch: set by the clear command, lifted by a load or by CRC completion.
  always_ff @(posedge clk) begin
    if (!rstN)                               suppress <= 1'b0;
    else if (pendClrCmd)                     suppress <= 1'b1;
    else if (strobes.takeLoad || crcDone)    suppress <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 eomFlag <= 1'b0;
    else if (abortCmd)         eomFlag <= 1'b1;
    else if (strobes.takeLoad) eomFlag <= 1'b0;
  end

  assign txIrq = intPending & txIntEn;

  a_r5_clear_cmd: assert property (@(posedge clk) disable iff (!rstN)
    pendClrCmd |=> !intPending);
  a_r5_no_set_when_suppressed: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intPending) |-> $past(!suppress && drainPulse));
  a_r6_lift: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.takeLoad || crcDone) && !pendClrCmd) |=> !suppress);
  a_r7_eom_set: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd |=> eomFlag);

endmodule

// File: rtl/tx_abort_dp.sv
module tx_abort_dp
  import tx_abort_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] loadData,
  input  logic              bitEn,
  output logic              txBit,
  output logic              bufFull,
  output logic              abortBusy,
  output logic              drainPulse
);

  localparam int SH_CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int AB_CW = (ABORT_LEN > 1) ? $clog2(ABORT_LEN) : 1;
  localparam logic [SH_CW-1:0] SH_LAST = SH_CW'(DATA_W - 1);
  localparam logic [AB_CW-1:0] AB_LAST = AB_CW'(ABORT_LEN - 1);

  logic [DATA_W-1:0] holdBuf;
  logic [DATA_W-1:0] shReg;
  logic              shBusy;
  logic [SH_CW-1:0]  shCnt;
  logic [AB_CW-1:0]  abCnt;
  logic              xfer;

  assign xfer       = bitEn && !abortBusy && !shBusy && bufFull && !strobes.startAbort;
  assign drainPulse = (strobes.startAbort && bufFull) || (xfer && !strobes.takeLoad);
  assign txBit      = abortBusy ? 1'b1 : (shBusy ? shReg[0] : 1'b1);

  // Holding buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      holdBuf <= '0;
    end else if (strobes.startAbort) begin
      bufFull <= 1'b0;
    end else if (strobes.takeLoad) begin
      bufFull <= 1'b1;
      holdBuf <= loadData;
    end else if (xfer) begin
      bufFull <= 1'b0;
    end
  end

  // Shifter, least significant bit first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shBusy <= 1'b0;
      shReg  <= '0;
      shCnt  <= '0;
    end else if (strobes.startAbort) begin
      shBusy <= 1'b0;
      shCnt  <= '0;
    end else if (xfer) begin
      shBusy <= 1'b1;
      shReg  <= holdBuf;
      shCnt  <= '0;
    end else if (shBusy && bitEn) begin
      shReg <= shReg >> 1;
      shCnt <= shCnt + 1'b1;
      if (shCnt == SH_LAST) shBusy <= 1'b0;
    end
  end

  // Abort run of marking bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortBusy <= 1'b0;
      abCnt     <= '0;
    end else if (strobes.startAbort) begin
      abortBusy <= 1'b1;
      abCnt     <= '0;
    end else if (abortBusy && bitEn) begin
      abCnt <= abCnt + 1'b1;
      if (abCnt == AB_LAST) abortBusy <= 1'b0;
    end
  end

  a_r7_flush: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startAbort |=> (!bufFull && abortBusy && !shBusy));
  a_r7_line_marks: assert property (@(posedge clk) disable iff (!rstN)
    abortBusy |-> txBit);
  a_r9_stay_empty: assert property (@(posedge clk) disable iff (!rstN)
    abortBusy |-> !bufFull);
  a_r3_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    (!abortBusy && !shBusy) |-> txBit);

endmodule

// File: rtl/tx_abort_ctl.sv
module tx_abort_ctl
  import tx_abort_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameMode,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  input  logic              crcDone,
  input  logic              txIntEn,
  input  logic              bitEn,
  output logic              txBit,
  output logic              abortBusy,
  output logic              bufFull,
  output logic              intPending,
  output logic              txIrq,
  output logic              eomFlag
);

  txStrobes_t strobes;
  logic       drainPulse;

  tx_abort_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameMode  (frameMode),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .loadValid  (loadValid),
    .crcDone    (crcDone),
    .txIntEn    (txIntEn),
    .abortBusy  (abortBusy),
    .drainPulse (drainPulse),
    .strobes    (strobes),
    .intPending (intPending),
    .txIrq      (txIrq),
    .eomFlag    (eomFlag)
  );

  tx_abort_dp #(
    .DATA_W    (DATA_W),
    .ABORT_LEN (ABORT_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .loadData   (loadData),
    .bitEn      (bitEn),
    .txBit      (txBit),
    .bufFull    (bufFull),
    .abortBusy  (abortBusy),
    .drainPulse (drainPulse)
  );

  a_r4_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    (intPending && txIntEn) |-> txIrq);
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'b101 && drainPulse) |=> !intPending);

endmodule

// File: tb/tx_abort_ctl_bench.sv
`timescale 1ns/1ps
module tx_abort_ctl_bench;

  localparam int W   = 8;
  localparam int LEN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameMode = 1'b1, cmdValid = 1'b0, loadValid = 1'b0, crcDone = 1'b0;
  logic txIntEn = 1'b0, bitEn = 1'b0;
  logic [2:0] cmdCode = 3'b000;
  logic [W-1:0] loadData = '0;
  logic txBit, abortBusy, bufFull, intPending, txIrq, eomFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tx_abort_ctl #(.DATA_W(W), .ABORT_LEN(LEN)) u_tx_abort_ctl (
    .clk(clk), .rstN(rstN), .frameMode(frameMode), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .loadValid(loadValid), .loadData(loadData),
    .crcDone(crcDone), .txIntEn(txIntEn), .bitEn(bitEn), .txBit(txBit),
    .abortBusy(abortBusy), .bufFull(bufFull), .intPending(intPending),
    .txIrq(txIrq), .eomFlag(eomFlag)
  );

  // Reference model state
  logic [W-1:0] mBuf, mSh;
  logic mFull, mShBusy, mAbort, mPend, mSupp, mEom;
  int   mShCnt, mAbCnt;

  function automatic logic expTxBit();
    return mAbort ? 1'b1 : (mShBusy ? mSh[0] : 1'b1);
  endfunction

  task automatic modelReset();
    mBuf = '0; mSh = '0; mFull = 0; mShBusy = 0; mAbort = 0;
    mPend = 0; mSupp = 0; mEom = 0; mShCnt = 0; mAbCnt = 0;
  endtask

  task automatic modelStep();
    logic abortCmd, clrCmd, ld, xf, drain;
    abortCmd = cmdValid && cmdCode == 3'b011 && frameMode;
    clrCmd   = cmdValid && cmdCode == 3'b101;
    ld       = loadValid && !mAbort && !abortCmd;
    xf       = bitEn && !mAbort && !mShBusy && mFull && !abortCmd;
    drain    = (abortCmd && mFull) || (xf && !ld);
    if (clrCmd) mPend = 0;
    else if (ld) mPend = 0;
    else if (drain && !mSupp) mPend = 1;
    if (clrCmd) mSupp = 1;
    else if (ld || crcDone) mSupp = 0;
    if (abortCmd) begin
      mAbort = 1; mAbCnt = 0; mFull = 0; mShBusy = 0; mShCnt = 0; mEom = 1;
    end else begin
      if (mAbort && bitEn) begin
        if (mAbCnt == LEN - 1) mAbort = 0;
        mAbCnt++;
      end
      if (xf) begin
        mSh = mBuf; mShBusy = 1; mShCnt = 0;
      end else if (mShBusy && bitEn) begin
        mSh = mSh >> 1;
        if (mShCnt == W - 1) mShBusy = 0;
        mShCnt++;
      end
      if (ld) begin mBuf = loadData; mFull = 1; mEom = 0; end
      else if (xf) mFull = 0;
    end
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R2 bufFull", bufFull, mFull);
    check("R3 txBit", txBit, expTxBit());
    check("R4 intPending", intPending, mPend);
    check("R4 txIrq", txIrq, mPend & txIntEn);
    check("R7 eomFlag", eomFlag, mEom);
    check("R7 abortBusy", abortBusy, mAbort);
  endtask

  // One clock: inputs already driven; step model at the edge, compare at the falling edge.
  task automatic tick();
    @(posedge clk);
    if (rstN) modelStep(); else modelReset();
    @(negedge clk);
    compareAll();
    cmdValid = 0; loadValid = 0; crcDone = 0; bitEn = 0;
  endtask

  task automatic doLoad(logic [W-1:0] d);
    loadValid = 1; loadData = d; tick();
  endtask

  task automatic doCmd(logic [2:0] c);
    cmdValid = 1; cmdCode = c; tick();
  endtask

  task automatic bits(int n);
    for (int i = 0; i < n; i++) begin bitEn = 1; tick(); end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk); tick(); tick();
    rstN = 1;
    check("R1 bufFull", bufFull, 1'b0);
    check("R1 intPending", intPending, 1'b0);
    check("R1 txIrq", txIrq, 1'b0);
    check("R1 eomFlag", eomFlag, 1'b0);
    check("R1 abortBusy", abortBusy, 1'b0);
    check("R1 txBit", txBit, 1'b1);

    // R2, R3, R4: load, drain, serialize
    txIntEn = 1; frameMode = 1;
    doLoad(8'hA5);
    check("R2 load fills", bufFull, 1'b1);
    bits(1);
    check("R3 buffer drained", bufFull, 1'b0);
    check("R4 pending on drain", intPending, 1'b1);
    check("R4 irq with enable", txIrq, 1'b1);
    for (int i = 0; i < W; i++) begin
      check("R3 serial bit", txBit, 1'((8'hA5 >> i) & 1));
      bitEn = 1; tick();
    end
    check("R3 idle mark", txBit, 1'b1);

    // R5: suppressed drain
    doLoad(8'h3C);
    doCmd(3'b101);
    check("R5 clear", intPending, 1'b0);
    bits(1);
    check("R5 suppressed drain", intPending, 1'b0);
    bits(W);

    // R6: crcDone lifts suppression
    doLoad(8'h0F);
    doCmd(3'b101);
    crcDone = 1; tick();
    bits(1);
    check("R6 lifted by crcDone", intPending, 1'b1);
    bits(W);

    // R7, R9: abort with zero data in flight
    doLoad(8'h00);
    bits(1);
    doLoad(8'h00);
    check("R7 data zero in flight", txBit, 1'b0);
    doCmd(3'b011);
    check("R7 buffer flushed", bufFull, 1'b0);
    check("R7 eom set", eomFlag, 1'b1);
    check("R7 abort busy", abortBusy, 1'b1);
    doLoad(8'h77);
    check("R9 load dropped", bufFull, 1'b0);
    for (int i = 0; i < LEN; i++) begin
      check("R7 run of ones", txBit, 1'b1);
      check("R7 busy during run", abortBusy, 1'b1);
      bitEn = 1; tick();
    end
    check("R7 run ended", abortBusy, 1'b0);
    cmdValid = 1; cmdCode = 3'b011; loadValid = 1; loadData = 8'h12; tick();
    check("R9 load with abort dropped", bufFull, 1'b0);
    bits(LEN);

    // R8: abort outside framing mode, and an unused code
    frameMode = 0;
    doLoad(8'h11);
    doCmd(3'b011);
    check("R8 abort ignored buf", bufFull, 1'b1);
    check("R8 abort ignored busy", abortBusy, 1'b0);
    check("R8 abort ignored eom", eomFlag, 1'b0);
    doCmd(3'b010);
    check("R8 other code ignored", bufFull, 1'b1);
    frameMode = 1;

    // R10: clear command coincides with drain
    bitEn = 1; cmdValid = 1; cmdCode = 3'b101; tick();
    check("R10 clear beats set", intPending, 1'b0);
    check("R10 drain happened", bufFull, 1'b0);
    bits(W);

    // Random phase against the model
    void'($urandom(32'h00C0FFEE));
    for (int n = 0; n < 4000; n++) begin
      cmdValid  = ($urandom % 10) == 0;
      cmdCode   = 3'($urandom);
      loadValid = ($urandom % 5) == 0;
      loadData  = W'($urandom);
      bitEn     = ($urandom % 2) == 0;
      crcDone   = ($urandom % 30) == 0;
      if (($urandom % 50) == 0) frameMode = ~frameMode;
      if (($urandom % 20) == 0) txIntEn = ~txIntEn;
      tick();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule